// File: doc/BRIEF.md
# Two-Level Local History Branch Direction Predictor

This block predicts the direction of conditional branches from each branch's own recent past. A small fully associative history cache, looked up by a partial tag folded from the branch address, keeps a short shift register of outcomes for every tracked branch. The selected history, merged with low address bits, points into one table of 2-bit saturating counters that all branches share. The most significant bit of the chosen counter is the prediction.

The fetch side presents an address on the predict port and gets hit and direction back in the same cycle. Each hit moves a speculative copy of the history forward using the predicted direction, so later lookups of the same branch see it before it resolves. The execute side returns the real outcome and a mispredict flag on the resolve port. That updates the real history and the counter. On a misprediction the speculative copy is restored from the real one. Both ports carry a valid bit and have no ready: every valid beat is taken in its cycle and there is no back-pressure. A parameter chooses whether history and address bits are concatenated or XORed to form the counter index.

Top module: `lhist_predictor`

## Requirements
- R1: A history is HIST_W bits. Each update shifts the new outcome into bit 0 and discards the top bit.
- R2: The tag is the address folded to TAG_W bits: address bit i is XORed into tag bit i mod TAG_W. A lookup hits when a valid entry holds that tag. Addresses with equal fold alias to one entry.
- R3: On a predict miss, pred_hit and pred_taken are 0. A resolve miss writes tag, all-zero real and speculative history and a clear speculation bit into the round-robin victim slot (0,1,..,ENTRIES-1,0..). It leaves the counters alone.
- R4: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken outcome increments and stops at 11. A not-taken outcome decrements and stops at 00.
- R5: The prediction is the counter MSB. After reset every counter is 10 and no cache entry is valid.
- R6: In concatenation mode the counter index is {history, addr[ADDR_BITS-1:0]}.
- R7: In XOR mode the counter index is history ^ addr[HIST_W-1:0].
- R8: A predict hit shifts the predicted direction into that entry's speculative history and sets its speculation bit. Predictions use the speculative history while the bit is set, and never modify counters.
- R9: A resolve hit updates the counter indexed by the entry's real history, taken before the update, together with res_addr. It then shifts res_taken into the real history.
- R10: A resolve hit with res_mispredict set copies the updated real history into the speculative history and clears the speculation bit.
- R11: A predict and a mispredicted resolve of the same entry in one cycle take effect resolve first: the prediction uses the repaired history. Counters are read as stored before that cycle's write.
- R12: With pred_valid low, pred_hit and pred_taken are 0. Predict outputs are combinational in the cycle of the request, and both ports accept every valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Predict request present |
| pred_addr | input | ADDR_W | Branch address to predict |
| pred_hit | output | 1 | History cache hit for pred_addr |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | Resolve beat present |
| res_addr | input | ADDR_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_mispredict | input | 1 | The earlier prediction was wrong |

## Verification
The bench targets four cases. The first is the fifth allocation into four slots: a victim pointer that fails to wrap evicts the wrong branch or overwrites a live one. The second is counters pushed past both ends: a design that wraps turns a strong prediction into its opposite. The third is a burst of predictions with no resolve, followed by a mispredict: a design that fails to repair keeps indexing with a stale shifted history. The fourth is a repair arriving in the same cycle as a lookup: without forwarding, that lookup uses the wrong counter. Address aliases through the tag fold, and both index modes, are checked against an arithmetic reference on every cycle of a long pseudo-random run.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  typedef enum logic {
    IDX_CAT = 1'b0,
    IDX_XOR = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/lhp_index.sv
module lhp_index
  import lhp_pkg::*;
#(
  parameter idx_mode_e MODE = IDX_CAT,
  parameter int HIST_W = 4,
  parameter int LOW_W = 2,
  parameter int IDX_W = 6
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [LOW_W-1:0]  low,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (MODE == IDX_XOR) begin : g_xor
      assign idx = hist ^ low;
    end else begin : g_cat
      assign idx = {hist, low};
    end
  endgenerate
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] cnt [DEPTH];

  assign rd_taken = cnt[rd_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= 2'b10;
    end else if (wr_en) begin
      if (wr_taken && cnt[wr_idx] != 2'b11) cnt[wr_idx] <= cnt[wr_idx] + 2'd1;
      else if (!wr_taken && cnt[wr_idx] != 2'b00) cnt[wr_idx] <= cnt[wr_idx] - 2'd1;
    end
  end

  assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && cnt[wr_idx] == 2'b11) |=> cnt[$past(wr_idx)] == 2'b11);
  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && cnt[wr_idx] == 2'b00) |=> cnt[$past(wr_idx)] == 2'b00);
  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && cnt[wr_idx] != 2'b11) |=>
      cnt[$past(wr_idx)] == 2'($past(cnt[wr_idx]) + 2'd1));
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cnt[$past(rd_idx)] == $past(cnt[rd_idx]));
endmodule

// File: rtl/lhp_hist_cache.sv
module lhp_hist_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W = 8,
  parameter int HIST_W = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_en,
  input  logic [ADDR_W-1:0] pd_addr,
  input  logic              pd_taken,
  output logic              pd_hit,
  output logic [HIST_W-1:0] pd_hist,
  input  logic              rs_en,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken,
  input  logic              rs_mis,
  output logic              rs_hit,
  output logic [HIST_W-1:0] rs_hist
);
  localparam int RR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] val, sb, pd_match, rs_match;
  logic [TAG_W-1:0]   tag [ENTRIES];
  logic [HIST_W-1:0]  real_h [ENTRIES];
  logic [HIST_W-1:0]  spec_h [ENTRIES];
  logic [RR_W-1:0]    rr, pd_way, rs_way;
  logic [TAG_W-1:0]   pd_tag, rs_tag;
  logic [HIST_W-1:0]  real_next, pd_base;
  logic               fwd, alloc;

  always_comb begin
    pd_tag = '0;
    rs_tag = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      pd_tag[i % TAG_W] = pd_tag[i % TAG_W] ^ pd_addr[i];
      rs_tag[i % TAG_W] = rs_tag[i % TAG_W] ^ rs_addr[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign pd_match[g] = val[g] && (tag[g] == pd_tag);
      assign rs_match[g] = val[g] && (tag[g] == rs_tag);
    end
  endgenerate

  always_comb begin
    pd_way = '0;
    rs_way = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (pd_match[i]) pd_way = RR_W'(i);
      if (rs_match[i]) rs_way = RR_W'(i);
    end
  end

  assign pd_hit    = |pd_match;
  assign rs_hit    = |rs_match;
  assign rs_hist   = real_h[rs_way];
  assign real_next = {rs_hist[HIST_W-2:0], rs_taken};
  assign fwd       = rs_en && rs_hit && rs_mis && pd_hit && (rs_way == pd_way);
  assign pd_base   = sb[pd_way] ? spec_h[pd_way] : real_h[pd_way];
  assign pd_hist   = fwd ? real_next : pd_base;
  assign alloc     = rs_en && !rs_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      sb  <= '0;
      rr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i]    <= '0;
        real_h[i] <= '0;
        spec_h[i] <= '0;
      end
    end else begin
      if (rs_en && rs_hit) begin
        real_h[rs_way] <= real_next;
        if (rs_mis) begin
          spec_h[rs_way] <= real_next;
          sb[rs_way]     <= 1'b0;
        end
      end
      if (pd_en && pd_hit) begin
        spec_h[pd_way] <= {pd_hist[HIST_W-2:0], pd_taken};
        sb[pd_way]     <= 1'b1;
      end
      if (alloc) begin
        val[rr]    <= 1'b1;
        tag[rr]    <= rs_tag;
        real_h[rr] <= '0;
        spec_h[rr] <= '0;
        sb[rr]     <= 1'b0;
        rr         <= (rr == RR_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  assert_one_pd_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pd_match));
  assert_one_rs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rs_match));
  assert_alloc_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (real_h[$past(rr)] == '0) && val[$past(rr)]);
  assert_rr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(rr));
  assert_repair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_en && rs_hit && rs_mis && !(pd_en && pd_hit && pd_way == rs_way)) |=>
      (spec_h[$past(rs_way)] == real_h[$past(rs_way)]) && !sb[$past(rs_way)]);
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor
  import lhp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ENTRIES = 4,
  parameter int TAG_W = 8,
  parameter int HIST_W = 4,
  parameter int ADDR_BITS = 2,
  parameter idx_mode_e MODE = IDX_CAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_hit,
  output logic              pred_taken,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_taken,
  input  logic              res_mispredict
);
  localparam int LOW_W = (MODE == IDX_XOR) ? HIST_W : ADDR_BITS;
  localparam int IDX_W = (MODE == IDX_XOR) ? HIST_W : HIST_W + ADDR_BITS;

  logic              c_pd_hit, c_rs_hit, ctr_taken;
  logic [HIST_W-1:0] pd_hist, rs_hist;
  logic [IDX_W-1:0]  pd_idx, rs_idx;

  lhp_hist_cache #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)
  ) u_cache (
    .clk(clk), .rst_n(rst_n),
    .pd_en(pred_valid), .pd_addr(pred_addr), .pd_taken(ctr_taken),
    .pd_hit(c_pd_hit), .pd_hist(pd_hist),
    .rs_en(res_valid), .rs_addr(res_addr), .rs_taken(res_taken),
    .rs_mis(res_mispredict), .rs_hit(c_rs_hit), .rs_hist(rs_hist)
  );

  lhp_index #(.MODE(MODE), .HIST_W(HIST_W), .LOW_W(LOW_W), .IDX_W(IDX_W)) u_pd_idx (
    .hist(pd_hist), .low(pred_addr[LOW_W-1:0]), .idx(pd_idx)
  );

  lhp_index #(.MODE(MODE), .HIST_W(HIST_W), .LOW_W(LOW_W), .IDX_W(IDX_W)) u_rs_idx (
    .hist(rs_hist), .low(res_addr[LOW_W-1:0]), .idx(rs_idx)
  );

  lhp_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pd_idx), .rd_taken(ctr_taken),
    .wr_en(res_valid && c_rs_hit), .wr_idx(rs_idx), .wr_taken(res_taken)
  );

  assign pred_hit   = pred_valid && c_pd_hit;
  assign pred_taken = pred_hit && ctr_taken;
endmodule

// File: tb/tb_lhist_predictor.sv
`timescale 1ns/1ps
module tb_lhist_predictor;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pv, rv, rt, rm;
  logic [15:0] pa, ra;
  logic hit_c, tk_c, hit_x, tk_x;
  int tests = 0, fails = 0;

  lhist_predictor #(.ADDR_W(16), .ENTRIES(4), .TAG_W(8), .HIST_W(4), .ADDR_BITS(2),
    .MODE(lhp_pkg::IDX_CAT)) dut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pv), .pred_addr(pa), .pred_hit(hit_c),
    .pred_taken(tk_c), .res_valid(rv), .res_addr(ra), .res_taken(rt), .res_mispredict(rm));

  lhist_predictor #(.ADDR_W(16), .ENTRIES(4), .TAG_W(8), .HIST_W(4), .ADDR_BITS(2),
    .MODE(lhp_pkg::IDX_XOR)) dut_xor (
    .clk(clk), .rst_n(rst_n), .pred_valid(pv), .pred_addr(pa), .pred_hit(hit_x),
    .pred_taken(tk_x), .res_valid(rv), .res_addr(ra), .res_taken(rt), .res_mispredict(rm));

  // reference state, index 0 = concatenation, 1 = XOR
  bit         mv [2][4];
  bit         msb [2][4];
  logic [7:0] mtag [2][4];
  logic [3:0] mreal [2][4];
  logic [3:0] mspec [2][4];
  int         mrr [2];
  logic [1:0] mctr [2][64];

  function automatic int midx(int m, logic [3:0] h, logic [15:0] a);
    if (m == 0) return int'({h, a[1:0]});
    return int'(h ^ a[3:0]);
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      mrr[m] = 0;
      for (int i = 0; i < 4; i++) begin
        mv[m][i] = 0; msb[m][i] = 0; mtag[m][i] = '0; mreal[m][i] = '0; mspec[m][i] = '0;
      end
      for (int i = 0; i < 64; i++) mctr[m][i] = 2'b10;
    end
  endtask

  task automatic step(input logic p_v, input logic [15:0] p_a, input logic r_v,
                      input logic [15:0] r_a, input logic r_t, input logic r_m,
                      input string tag);
    @(negedge clk);
    pv = p_v; pa = p_a; rv = r_v; ra = r_a; rt = r_t; rm = r_m;
    #1;
    for (int m = 0; m < 2; m++) begin
      int p, r, ci;
      logic [7:0] ptag, rtag;
      logic [3:0] h, rnext;
      logic eh, et, ah, at;
      ptag = p_a[15:8] ^ p_a[7:0];
      rtag = r_a[15:8] ^ r_a[7:0];
      p = -1; r = -1;
      for (int i = 0; i < 4; i++) begin
        if (mv[m][i] && mtag[m][i] == ptag) p = i;
        if (mv[m][i] && mtag[m][i] == rtag) r = i;
      end
      rnext = (r >= 0) ? {mreal[m][r][2:0], r_t} : 4'h0;
      eh = 0; et = 0; h = '0;
      if (p_v && p >= 0) begin
        eh = 1;
        if (r_v && r == p && r_m) h = rnext;
        else h = msb[m][p] ? mspec[m][p] : mreal[m][p];
        et = mctr[m][midx(m, h, p_a)][1];
      end
      ah = (m == 0) ? hit_c : hit_x;
      at = (m == 0) ? tk_c : tk_x;
      tests++;
      if (ah !== eh || at !== et) begin
        fails++;
        $display("FAIL %s mode%0d addr %h: hit/taken got %b%b expected %b%b",
                 tag, m, p_a, ah, at, eh, et);
      end
      if (r_v && r >= 0) begin
        ci = midx(m, mreal[m][r], r_a);
        if (r_t && mctr[m][ci] != 2'b11) mctr[m][ci] = mctr[m][ci] + 2'd1;
        if (!r_t && mctr[m][ci] != 2'b00) mctr[m][ci] = mctr[m][ci] - 2'd1;
        mreal[m][r] = rnext;
        if (r_m) begin mspec[m][r] = rnext; msb[m][r] = 0; end
      end
      if (eh) begin mspec[m][p] = {h[2:0], et}; msb[m][p] = 1; end
      if (r_v && r < 0) begin
        mv[m][mrr[m]] = 1; mtag[m][mrr[m]] = rtag; mreal[m][mrr[m]] = '0;
        mspec[m][mrr[m]] = '0; msb[m][mrr[m]] = 0;
        mrr[m] = (mrr[m] + 1) % 4;
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R12 watchdog: run still active, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; pv = 0; rv = 0; rt = 0; rm = 0; pa = '0; ra = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R5 R12: reset state and idle outputs
    step(0, 16'h0013, 0, 16'h0, 0, 0, "R12 idle");
    step(1, 16'h0013, 0, 16'h0, 0, 0, "R5 empty after reset");
    // R3: misses predict not taken
    for (int a = 0; a < 8; a++) step(1, 16'(a * 16 + 3), 0, 16'h0, 0, 0, "R3 miss");
    // R3 R2: five allocations into four slots, then lookups and an alias
    for (int k = 1; k <= 5; k++) step(0, 16'h0, 1, 16'(k * 17), 0, 0, "R3 alloc");
    for (int k = 1; k <= 5; k++) step(1, 16'(k * 17), 0, 16'h0, 0, 0, "R3 round robin");
    step(1, 16'h2200, 0, 16'h0, 0, 0, "R2 tag fold alias");
    step(1, 16'h2300, 0, 16'h0, 0, 0, "R2 tag mismatch");
    // R4 R9 R1: counter saturation both ways, history shifting
    for (int k = 0; k < 14; k++) begin
      step(0, 16'h0, 1, 16'h0044, (k >= 3 && k < 10), 0, "R9 resolve");
      step(1, 16'h0044, 0, 16'h0, 0, 0, "R4 R1 after resolve");
    end
    for (int k = 0; k < 6; k++) begin
      step(0, 16'h0, 1, 16'h0044, 1'b1, 0, "R4 saturate high");
      step(1, 16'h0044, 0, 16'h0, 0, 0, "R4 saturate high");
    end
    // R8 R10: speculative burst then repair
    for (int k = 0; k < 5; k++) step(1, 16'h0055, 0, 16'h0, 0, 0, "R8 speculative");
    step(0, 16'h0, 1, 16'h0055, 0, 1, "R10 repair");
    step(1, 16'h0055, 0, 16'h0, 0, 0, "R10 after repair");
    step(1, 16'h0055, 0, 16'h0, 0, 0, "R8 speculative again");
    // R11: repair and predict of the same branch in one cycle
    step(1, 16'h0055, 1, 16'h0055, 1, 1, "R11 same cycle");
    step(1, 16'h0055, 1, 16'h0055, 0, 1, "R11 same cycle");
    step(1, 16'h0055, 0, 16'h0, 0, 0, "R11 follow-up");
    // R6 R7 R12: long mixed run over both index modes
    lf = 32'hACE1_2468;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pl, rl;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pl = 8'(lf[2:0] * 37 + 1);
      rl = 8'(lf[10:8] * 37 + 1);
      step(lf[4] | lf[5], lf[6] ? {pl, 8'h00} : {8'h00, pl},
           lf[12] | lf[13], lf[14] ? {rl, 8'h00} : {8'h00, rl},
           lf[16], lf[17] & lf[18], "R6 R7 mixed");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule